// File: doc/BRIEF.md
# UART Transmit Ready and Empty Flags

This block keeps the two status flags a host reads before it feeds a UART transmitter: a ready flag that says the transmit holding FIFO can take another character, and an empty flag that says the transmitter has run dry. The empty state means the last stop bit has gone out and nothing is queued. The block tracks how full the FIFO is and whether the shift register holds a character. It reacts to host write strobes, to strobes from the serializer marking a load into the shift register and the end of a stop bit, and to enable, disable and reset commands.

A disable command given while a character is on the line does not act at once. It stays pending until that character's stop bit has gone out, and an enable given in the meantime cancels it. A host write made while the ready flag is low is thrown away, and the block pulses a drop indication for it. The serializer, the baud timing and the FIFO storage are outside this block.

Top module: `uart_tx_status`

## Requirements
- R1: A transmitter reset command (`txrst_i` high for one cycle) drives both flags to 0 on the next cycle, empties the occupancy count and leaves the transmitter disabled, so later writes are dropped until an enable.
- R2: An enable command while the transmitter is disabled sets both `txrdy_o` and `txemt_o` on the next cycle, whether the disable came from reset or from a disable command.
- R3: `txrdy_o` is 1 exactly when the transmitter is enabled, no disable is pending and fewer than DEPTH characters are queued; an accepted write that takes the last free slot clears it on the next cycle.
- R4: A load strobe that moves a character from a full FIFO into the shift register sets `txrdy_o` on the next cycle.
- R5: A write accepted while `txrdy_o` is 1 clears `txemt_o` on the next cycle.
- R6: A stop-done strobe with no queued character and no load in the same cycle sets `txemt_o` on the next cycle. With characters still queued, `txemt_o` stays 0.
- R7: A write while `txrdy_o` is 0 is discarded. `wr_drop_o` is 1 for the one cycle that follows it, and the occupancy count does not change.
- R8: A disable command while the shift register is idle clears both flags on the next cycle. This includes the underrun state, where both flags were 1.
- R9: A disable command while a character is shifting clears `txrdy_o` on the next cycle and is held pending. At that character's stop-done strobe the transmitter becomes disabled with `txemt_o` staying 0.
- R10: An enable command while a disable is pending cancels it. `txrdy_o` returns on the next cycle if the FIFO has room, and the following stop-done strobe with nothing queued sets `txemt_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe into the transmit FIFO |
| load_i | input | 1 | Serializer takes the FIFO head into the shift register |
| stop_done_i | input | 1 | Last stop bit of the shifting character has been sent |
| en_cmd_i | input | 1 | Transmitter enable command |
| dis_cmd_i | input | 1 | Transmitter disable command |
| txrst_i | input | 1 | Transmitter reset command |
| txrdy_o | output | 1 | FIFO can accept a character |
| txemt_o | output | 1 | Transmitter underrun: nothing shifting, nothing queued |
| wr_drop_o | output | 1 | Previous cycle's write was discarded |

## Verification
Every output is registered, so each flag change and each drop pulse is due exactly one clock edge after the command or strobe that causes it. For every stimulus cycle, the driver computes the expected flag and drop values from a behavioural model of the requirements and queues them. The monitor samples two time units after the following rising edge and compares the oldest queued entry there, so each comparison falls in the single cycle where the result first becomes valid. The pending-disable and cancel cases keep the shift register busy across several idle cycles, to show the flags do not move early.

// File: rtl/uart_tx_status_pkg.sv
package uart_tx_status_pkg;
  typedef enum logic [1:0] {
    TX_OFF   = 2'd0,
    TX_ON    = 2'd1,
    TX_DRAIN = 2'd2   // disable pending, current character finishing
  } tx_mode_e;
endpackage

// File: rtl/tx_occupancy.sv
module tx_occupancy #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [CW-1:0] cnt_next_o,
  output logic          full_o
);
  logic [CW-1:0] cnt_q;
  logic          pop_ok;

  assign pop_ok = pop_i && (cnt_q != '0);

  always_comb begin
    cnt_next_o = cnt_q;
    if (clr_i) cnt_next_o = '0;
    else begin
      unique case ({push_i, pop_ok})
        2'b10:   cnt_next_o = cnt_q + CW'(1);
        2'b01:   cnt_next_o = cnt_q - CW'(1);
        default: cnt_next_o = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_next_o;
  end

  assign full_o = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/tx_mode_ctrl.sv
module tx_mode_ctrl
  import uart_tx_status_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     en_cmd_i,
  input  logic     dis_cmd_i,
  input  logic     load_i,
  input  logic     stop_done_i,
  output tx_mode_e mode_q_o,
  output tx_mode_e mode_next_o,
  output logic     busy_q_o,
  output logic     enable_evt_o,
  output logic     disable_evt_o
);
  tx_mode_e mode_q, mode_d;
  logic     busy_q, busy_d;

  always_comb begin
    mode_d        = mode_q;
    enable_evt_o  = 1'b0;
    disable_evt_o = 1'b0;
    if (clr_i) begin
      mode_d = TX_OFF;
    end else begin
      unique case (mode_q)
        TX_OFF: if (en_cmd_i) begin
          mode_d       = TX_ON;
          enable_evt_o = 1'b1;
        end
        TX_ON: if (dis_cmd_i) begin
          if (busy_q && !stop_done_i) mode_d = TX_DRAIN;
          else begin
            mode_d        = TX_OFF;
            disable_evt_o = 1'b1;
          end
        end
        TX_DRAIN: begin
          if (en_cmd_i) mode_d = TX_ON;   // cancel pending disable
          else if (stop_done_i) begin
            mode_d        = TX_OFF;
            disable_evt_o = 1'b1;
          end
        end
        default: mode_d = TX_OFF;
      endcase
    end
  end

  always_comb begin
    if (clr_i)            busy_d = 1'b0;
    else if (load_i)      busy_d = 1'b1;
    else if (stop_done_i) busy_d = 1'b0;
    else                  busy_d = busy_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= TX_OFF;
      busy_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      busy_q <= busy_d;
    end
  end

  assign mode_q_o    = mode_q;
  assign mode_next_o = mode_d;
  assign busy_q_o    = busy_q;
endmodule

// File: rtl/tx_flag_gen.sv
module tx_flag_gen
  import uart_tx_status_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic          load_i,
  input  logic          stop_done_i,
  input  logic          enable_evt_i,
  input  logic          disable_evt_i,
  input  tx_mode_e      mode_next_i,
  input  logic [CW-1:0] cnt_next_i,
  output logic          accept_o,
  output logic          txrdy_o,
  output logic          txemt_o,
  output logic          wr_drop_o
);
  logic rdy_q, rdy_d, emt_q, emt_d, drop_q, drop_d;
  logic run_next;

  assign run_next = (mode_next_i == TX_ON);
  assign accept_o = wr_i && rdy_q && !clr_i;
  assign drop_d   = wr_i && !rdy_q && !clr_i;
  assign rdy_d    = !clr_i && run_next && (cnt_next_i < CW'(DEPTH));

  always_comb begin
    emt_d = emt_q;
    if (clr_i)              emt_d = 1'b0;
    else if (enable_evt_i)  emt_d = 1'b1;
    else if (disable_evt_i) emt_d = 1'b0;
    else if (accept_o)      emt_d = 1'b0;
    else if (stop_done_i && !load_i && run_next && (cnt_next_i == '0))
      emt_d = 1'b1;          // underrun
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      emt_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      rdy_q  <= rdy_d;
      emt_q  <= emt_d;
      drop_q <= drop_d;
    end
  end

  assign txrdy_o   = rdy_q;
  assign txemt_o   = emt_q;
  assign wr_drop_o = drop_q;
endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status
  import uart_tx_status_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic load_i,
  input  logic stop_done_i,
  input  logic en_cmd_i,
  input  logic dis_cmd_i,
  input  logic txrst_i,
  output logic txrdy_o,
  output logic txemt_o,
  output logic wr_drop_o
);
  localparam int CW = $clog2(DEPTH + 1);

  tx_mode_e      mode_q, mode_next;
  logic          busy_q, enable_evt, disable_evt;
  logic          accept, fifo_full;
  logic [CW-1:0] cnt_next;

  tx_mode_ctrl i_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (txrst_i),
    .en_cmd_i     (en_cmd_i),
    .dis_cmd_i    (dis_cmd_i),
    .load_i       (load_i),
    .stop_done_i  (stop_done_i),
    .mode_q_o     (mode_q),
    .mode_next_o  (mode_next),
    .busy_q_o     (busy_q),
    .enable_evt_o (enable_evt),
    .disable_evt_o(disable_evt)
  );

  tx_occupancy #(.DEPTH(DEPTH)) i_occ (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (txrst_i),
    .push_i    (accept),
    .pop_i     (load_i),
    .cnt_next_o(cnt_next),
    .full_o    (fifo_full)
  );

  tx_flag_gen #(.DEPTH(DEPTH)) i_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (txrst_i),
    .wr_i         (wr_i),
    .load_i       (load_i),
    .stop_done_i  (stop_done_i),
    .enable_evt_i (enable_evt),
    .disable_evt_i(disable_evt),
    .mode_next_i  (mode_next),
    .cnt_next_i   (cnt_next),
    .accept_o     (accept),
    .txrdy_o      (txrdy_o),
    .txemt_o      (txemt_o),
    .wr_drop_o    (wr_drop_o)
  );
endmodule

// File: rtl/uart_tx_status_chk.sv
module uart_tx_status_chk
  import uart_tx_status_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     wr_i,
  input logic     load_i,
  input logic     stop_done_i,
  input logic     en_cmd_i,
  input logic     dis_cmd_i,
  input logic     txrst_i,
  input logic     txrdy_o,
  input logic     txemt_o,
  input logic     wr_drop_o,
  input tx_mode_e mode_q,
  input logic     busy_q,
  input logic     fifo_full
);
  // R1
  tx_reset_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txrst_i |=> !txrdy_o && !txemt_o);
  // R2
  enable_sets_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_cmd_i && mode_q == TX_OFF && !txrst_i |=> txrdy_o && txemt_o);
  // R3
  ready_has_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txrdy_o |-> !fifo_full && mode_q == TX_ON);
  // R5
  write_clears_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && txrdy_o && !txrst_i |=> !txemt_o);
  // R7
  drop_flagged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !txrdy_o && !txrst_i |=> wr_drop_o);
  // R8
  idle_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_cmd_i && mode_q == TX_ON && !busy_q && !txrst_i |=> !txrdy_o && !txemt_o);
  // R9
  pending_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_cmd_i && mode_q == TX_ON && busy_q && !stop_done_i && !txrst_i
    |=> mode_q == TX_DRAIN && !txrdy_o);
endmodule

bind uart_tx_status uart_tx_status_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .load_i     (load_i),
  .stop_done_i(stop_done_i),
  .en_cmd_i   (en_cmd_i),
  .dis_cmd_i  (dis_cmd_i),
  .txrst_i    (txrst_i),
  .txrdy_o    (txrdy_o),
  .txemt_o    (txemt_o),
  .wr_drop_o  (wr_drop_o),
  .mode_q     (mode_q),
  .busy_q     (busy_q),
  .fifo_full  (fifo_full)
);

// File: tb/test_uart_tx_status.sv
module test_uart_tx_status;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, ld = 1'b0, sd = 1'b0, en = 1'b0, dis = 1'b0, trst = 1'b0;
  logic rdy, emt, drop;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  // behavioural model state
  bit m_on = 0, m_pend = 0, m_busy = 0, m_emt = 0, m_rdy = 0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_status #(.DEPTH(DEPTH)) i_uart_tx_status (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .load_i(ld), .stop_done_i(sd),
    .en_cmd_i(en), .dis_cmd_i(dis), .txrst_i(trst),
    .txrdy_o(rdy), .txemt_o(emt), .wr_drop_o(drop)
  );

  task automatic check(logic [2:0] act, logic [2:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {rdy,emt,drop} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one cycle of stimulus, expected result queued for the next edge
  task automatic step(bit w, bit e, bit d, bit l, bit s, bit r, string tag);
    bit acc, e_evt, d_evt, drp, popd;
    @(negedge clk);
    wr = w; en = e; dis = d; ld = l; sd = s; trst = r;
    drp = w && !m_rdy && !r;
    if (r) begin
      m_on = 0; m_pend = 0; m_cnt = 0; m_busy = 0; m_emt = 0;
    end else begin
      acc = w && m_rdy;
      e_evt = 0; d_evt = 0;
      if (!m_on) begin
        if (e) begin m_on = 1; e_evt = 1; end
      end else if (m_pend) begin
        if (e) m_pend = 0;
        else if (s) begin m_on = 0; m_pend = 0; d_evt = 1; end
      end else if (d) begin
        if (m_busy && !s) m_pend = 1;
        else begin m_on = 0; d_evt = 1; end
      end
      popd = l && (m_cnt > 0);
      m_cnt = m_cnt + int'(acc) - int'(popd);
      if (l) m_busy = 1; else if (s) m_busy = 0;
      if (e_evt) m_emt = 1;
      else if (d_evt) m_emt = 0;
      else if (acc) m_emt = 0;
      else if (s && !l && m_cnt == 0 && m_on && !m_pend) m_emt = 1;
    end
    m_rdy = m_on && !m_pend && (m_cnt < DEPTH);
    exp_q.push_back({m_rdy, m_emt, drp});
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor: sample two time units after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rdy, emt, drop}, e, t);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check({rdy, emt, drop}, 3'b000, "R1 reset state");
    @(negedge clk); rst_n = 1'b1;

    step(1, 0, 0, 0, 0, 0, "R7 write while disabled");
    step(0, 1, 0, 0, 0, 0, "R2 first enable");
    step(1, 0, 0, 0, 0, 0, "R5 write clears empty");
    step(0, 0, 0, 1, 0, 0, "R4 load");
    idle(2, "R6 shifting");
    step(0, 0, 0, 0, 1, 0, "R6 underrun");

    // fill, overflow, drain
    step(1, 0, 0, 0, 0, 0, "R3 fill");
    step(1, 0, 0, 0, 0, 0, "R3 fill");
    step(1, 0, 0, 0, 0, 0, "R3 fill");
    step(1, 0, 0, 0, 0, 0, "R3 last slot");
    step(1, 0, 0, 0, 0, 0, "R7 write when full");
    step(0, 0, 0, 1, 0, 0, "R4 load from full");
    step(0, 0, 0, 0, 1, 0, "R6 chars waiting");
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, 1, 0, 0, "R4 drain load");
      step(0, 0, 0, 0, 1, 0, "R7 drain count");
    end

    step(0, 0, 1, 0, 0, 0, "R8 disable in underrun");
    step(1, 0, 0, 0, 0, 0, "R7 write after disable");
    step(0, 1, 0, 0, 0, 0, "R2 re-enable");

    // pending disable
    step(1, 0, 0, 0, 0, 0, "R5 write");
    step(0, 0, 0, 1, 0, 0, "R4 load");
    step(0, 0, 1, 0, 0, 0, "R9 disable while shifting");
    idle(3, "R9 pending");
    step(0, 0, 0, 0, 1, 0, "R9 pending executes");
    step(1, 0, 0, 0, 0, 0, "R9 write after drain");

    // cancel pending disable
    step(0, 1, 0, 0, 0, 0, "R2 enable after drain");
    step(1, 0, 0, 0, 0, 0, "R5 write");
    step(0, 0, 0, 1, 0, 0, "R4 load");
    step(0, 0, 1, 0, 0, 0, "R9 disable pending");
    step(0, 1, 0, 0, 0, 0, "R10 cancel");
    idle(2, "R10 still shifting");
    step(0, 0, 0, 0, 1, 0, "R10 underrun after cancel");

    // reset with chars queued
    step(1, 0, 0, 0, 0, 0, "R5 write");
    step(1, 0, 0, 0, 0, 0, "R3 write");
    step(0, 0, 0, 0, 0, 1, "R1 transmitter reset");
    step(1, 0, 0, 0, 0, 0, "R1 write after reset");
    step(0, 1, 0, 0, 0, 0, "R2 enable after reset");
    step(1, 1, 1, 0, 0, 0, "R8 disable idle with char");

    // simultaneous write and load
    step(0, 1, 0, 0, 0, 0, "R2 enable");
    step(0, 0, 0, 1, 0, 0, "R4 load of old char");
    step(1, 0, 0, 0, 1, 0, "R6 stop with write");
    step(1, 0, 0, 1, 0, 0, "R3 write with load");
    step(0, 0, 0, 0, 1, 0, "R6 stop, one queued");
    step(0, 0, 0, 1, 0, 0, "R4 load");
    step(0, 0, 0, 0, 1, 0, "R6 underrun");
    idle(3, "R6 hold");

    wait (exp_q.size() == 0);
    @(posedge clk); #3;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule